// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block is the write-only configuration port of an audio converter. A host drives three lines: an active-low select, a serial clock and a serial data line. Both the select and the clock rest high. Each access is a 16-bit command word, sent most significant bit first. The word holds a two-bit device address, a direction flag, a five-bit register index and one data byte. Bits are taken on rising edges of the serial clock. The byte is stored only when the select line returns high, and only if the frame is complete and the device address matches two strap inputs.

The three host lines are sampled by the fast system clock through a synchronizer, and their edges are found in that domain. Five registers drive the datapath: interface format and master clock source, rate and clock ratio selection, output mixing with de-emphasis, level linking and soft mute, and the left and right channel levels. Every field comes out as its own port. A single timing-reset bit can be set from either of two registers. Holding the power-down input low returns every register to its default value and blocks all writes.

Top module: `ctl3w_regport`

## Requirements
- R1: While `pdn_n` is low, all outputs show the defaults. In raw byte terms these are index 0 = 0x0B, index 1 = 0x01, index 2 = 0x94, and indices 3 and 4 = 0xFF. So `ext_clk_sel`=0, `fmt_sel`=3'b101, `timing_run`=1, `fs_sel`=0, `spd_sel`=0, `mclk_sel`=0, `mix_sel`=4'b1001, `deemph_sel`=2'b01, `lvl_link`=0, `smute`=0, and both levels are 0xFF.
- R2: A frame is 16 bits, first bit = word bit 15. Bits 15:14 are the device address, bit 13 is the direction flag, bits 12:8 are the register index and bits 7:0 are the data. Each bit is captured on a rising `cclk` edge while `csel_n` is low. Outputs change only after `csel_n` rises, on the third system clock edge after that rise reaches the input pin. Holding `csel_n` low after the 16th bit leaves every output unchanged.
- R3: A frame whose bits 15:14 differ from `strap_addr` changes no output.
- R4: A frame whose direction bit 13 is 0 changes no output. A write needs this bit to be 1.
- R5: Only indices 0 to 4 exist. A frame with an index from 5 to 31 changes no output.
- R6: A frame is discarded if the number of rising `cclk` edges between the falling and rising edges of `csel_n` is anything other than 16.
- R7: Field layout:
  - index 0: bit 4 = `ext_clk_sel`, bits 3:1 = `fmt_sel`
  - index 1: bits 7:6 = `fs_sel`, bits 5:4 = `spd_sel`, bits 3:1 = `mclk_sel`
  - index 2: bits 7:4 = `mix_sel`, bits 3:2 = `deemph_sel`, bit 1 = `lvl_link`, bit 0 = `smute`
  - index 3: `lvl_left`
  - index 4: `lvl_right`
- R8: Bit 0 of a write to index 0 or index 1 sets the one shared `timing_run` bit. The most recent such write decides its value.
- R9: Clearing `timing_run` leaves every other register unchanged. Frames sent while `pdn_n` is low are lost: after release, the defaults remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all host lines are sampled with it |
| pdn_n | input | 1 | Power-down, active low; asynchronously restores defaults |
| strap_addr | input | 2 | Device address straps compared with frame bits 15:14 |
| csel_n | input | 1 | Host select, active low, idles high |
| cclk | input | 1 | Host serial clock, idles high |
| cdata | input | 1 | Host serial data, MSB first |
| ext_clk_sel | output | 1 | Master clock source select |
| fmt_sel | output | 3 | Serial audio format select |
| fs_sel | output | 2 | Sample-rate family select |
| spd_sel | output | 2 | Half/normal/double speed select |
| mclk_sel | output | 3 | Master clock ratio select |
| mix_sel | output | 4 | Output mixing mode |
| deemph_sel | output | 2 | De-emphasis select |
| lvl_link | output | 1 | Use the left level for both channels |
| smute | output | 1 | Soft mute request |
| timing_run | output | 1 | Shared timing reset bit; 0 holds timing in reset |
| lvl_left | output | 8 | Left channel level |
| lvl_right | output | 8 | Right channel level |

## Verification
The hardest case to reach is a frame that arrives with all 16 bits but must still be rejected. That includes a frame held open past its last bit, and a frame with exactly one clock edge too few or too many. In every such case the outputs must not move. The stimulus task drives the host lines at the pin level, and its edge count and the idle time before the select is released can be set freely. This lets the bench build 15-edge and 17-edge frames and frames with a long gap before release. The reference model, which updates only on an accepted release, is compared with all outputs every cycle, so an early or spurious commit shows up in the cycle it happens.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int FRAME_W  = 16;
  localparam int CHIP_W   = 2;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 5;
  localparam int NUM_CH   = 2;
  localparam int CNT_W    = $clog2(FRAME_W + 2);

  localparam int CHIP_LSB = FRAME_W - CHIP_W;
  localparam int RW_POS   = CHIP_LSB - 1;
  localparam int ADDR_LSB = RW_POS - ADDR_W;

  localparam logic [ADDR_W-1:0] IDX_IFACE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX_RATE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDX_MIX   = ADDR_W'(2);
  localparam int                IDX_LVL0  = 3;

  localparam logic [DATA_W-1:0] DEF_IFACE = 8'h0B;
  localparam logic [DATA_W-1:0] DEF_RATE  = 8'h01;
  localparam logic [DATA_W-1:0] DEF_MIX   = 8'h94;
  localparam logic [DATA_W-1:0] DEF_LVL   = 8'hFF;

  function automatic logic idx_exists(input logic [ADDR_W-1:0] idx);
    return int'(idx) < NUM_REGS;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (int'(c) > FRAME_W) ? c : c + CNT_W'(1);
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter import ctl3w_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_s,
  input  logic               ck_s,
  input  logic               d_s,
  output logic               cs_rise,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word,
  output logic [CNT_W-1:0]   bit_cnt
);
  logic cs_prev, ck_prev;
  logic cs_fall, ck_rise;

  assign cs_fall = !cs_s && cs_prev;
  assign cs_rise = cs_s && !cs_prev;
  assign ck_rise = ck_s && !ck_prev && !cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev    <= 1'b1;
      ck_prev    <= 1'b1;
      bit_cnt    <= '0;
      frame_word <= '0;
    end else begin
      cs_prev <= cs_s;
      ck_prev <= ck_s;
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (ck_rise) begin
        frame_word <= {frame_word[FRAME_W-2:0], d_s};
        bit_cnt    <= cnt_step(bit_cnt);
      end
    end
  end

  assign frame_vld = cs_rise && (int'(bit_cnt) == FRAME_W);
endmodule

// File: rtl/ctl3w_decode.sv
module ctl3w_decode import ctl3w_pkg::*; (
  input  logic               frame_vld,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic [CHIP_W-1:0]  strap_addr,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data
);
  logic chip_ok, dir_ok;

  assign wr_addr = frame_word[ADDR_LSB +: ADDR_W];
  assign wr_data = frame_word[DATA_W-1:0];
  assign chip_ok = frame_word[CHIP_LSB +: CHIP_W] == strap_addr;
  assign dir_ok  = frame_word[RW_POS];
  assign wr_en   = frame_vld && chip_ok && dir_ok && idx_exists(wr_addr);
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile import ctl3w_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ext_clk_sel,
  output logic [2:0]        fmt_sel,
  output logic [1:0]        fs_sel,
  output logic [1:0]        spd_sel,
  output logic [2:0]        mclk_sel,
  output logic [3:0]        mix_sel,
  output logic [1:0]        deemph_sel,
  output logic              lvl_link,
  output logic              smute,
  output logic              timing_run,
  output logic [DATA_W-1:0] lvl_left,
  output logic [DATA_W-1:0] lvl_right
);
  logic [3:0]        r_iface;
  logic [6:0]        r_rate;
  logic [7:0]        r_mix;
  logic              r_run;
  logic [DATA_W-1:0] r_lvl [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_iface <= DEF_IFACE[4:1];
      r_rate  <= DEF_RATE[7:1];
      r_mix   <= DEF_MIX;
      r_run   <= DEF_IFACE[0];
    end else if (wr_en) begin
      if (wr_addr == IDX_IFACE) begin
        r_iface <= wr_data[4:1];
        r_run   <= wr_data[0];
      end
      if (wr_addr == IDX_RATE) begin
        r_rate <= wr_data[7:1];
        r_run  <= wr_data[0];
      end
      if (wr_addr == IDX_MIX) r_mix <= wr_data;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_lvl[ch] <= DEF_LVL;
      else if (wr_en && wr_addr == ADDR_W'(IDX_LVL0 + ch))
        r_lvl[ch] <= wr_data;
    end
  end

  assign ext_clk_sel = r_iface[3];
  assign fmt_sel     = r_iface[2:0];
  assign fs_sel      = r_rate[6:5];
  assign spd_sel     = r_rate[4:3];
  assign mclk_sel    = r_rate[2:0];
  assign mix_sel     = r_mix[7:4];
  assign deemph_sel  = r_mix[3:2];
  assign lvl_link    = r_mix[1];
  assign smute       = r_mix[0];
  assign timing_run  = r_run;
  assign lvl_left    = r_lvl[0];
  assign lvl_right   = r_lvl[1];
endmodule

// File: rtl/ctl3w_regport.sv
module ctl3w_regport import ctl3w_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pdn_n,
  input  logic [CHIP_W-1:0] strap_addr,
  input  logic              csel_n,
  input  logic              cclk,
  input  logic              cdata,
  output logic              ext_clk_sel,
  output logic [2:0]        fmt_sel,
  output logic [1:0]        fs_sel,
  output logic [1:0]        spd_sel,
  output logic [2:0]        mclk_sel,
  output logic [3:0]        mix_sel,
  output logic [1:0]        deemph_sel,
  output logic              lvl_link,
  output logic              smute,
  output logic              timing_run,
  output logic [DATA_W-1:0] lvl_left,
  output logic [DATA_W-1:0] lvl_right
);
  logic [2:0]         pins_s;
  logic               cs_rise, frame_vld, wr_en;
  logic [FRAME_W-1:0] frame_word;
  logic [CNT_W-1:0]   bit_cnt;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;

  ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
    .clk(clk), .rst_n(pdn_n), .din({csel_n, cclk, cdata}), .dout(pins_s)
  );

  ctl3w_shifter shift_i (
    .clk(clk), .rst_n(pdn_n),
    .cs_s(pins_s[2]), .ck_s(pins_s[1]), .d_s(pins_s[0]),
    .cs_rise(cs_rise), .frame_vld(frame_vld),
    .frame_word(frame_word), .bit_cnt(bit_cnt)
  );

  ctl3w_decode dec_i (
    .frame_vld(frame_vld), .frame_word(frame_word), .strap_addr(strap_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ctl3w_regfile regs_i (
    .clk(clk), .rst_n(pdn_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk_sel(ext_clk_sel), .fmt_sel(fmt_sel), .fs_sel(fs_sel), .spd_sel(spd_sel),
    .mclk_sel(mclk_sel), .mix_sel(mix_sel), .deemph_sel(deemph_sel),
    .lvl_link(lvl_link), .smute(smute), .timing_run(timing_run),
    .lvl_left(lvl_left), .lvl_right(lvl_right)
  );
endmodule

// File: rtl/ctl3w_regport_chk.sv
module ctl3w_regport_chk import ctl3w_pkg::*; (
  input logic               clk,
  input logic               pdn_n,
  input logic [CHIP_W-1:0]  strap_addr,
  input logic               cs_rise,
  input logic               frame_vld,
  input logic               wr_en,
  input logic [FRAME_W-1:0] frame_word,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic               timing_run,
  input logic [DATA_W-1:0]  lvl_left,
  input logic [DATA_W-1:0]  lvl_right,
  input logic [3:0]         mix_sel
);
  logic [ADDR_W-1:0] f_addr;
  logic [23:0]       watched;
  assign f_addr  = frame_word[ADDR_LSB +: ADDR_W];
  assign watched = {timing_run, lvl_left, lvl_right, mix_sel, 3'b000};

  AST_WR_ONLY_ON_RELEASE: assert property (@(posedge clk) disable iff (!pdn_n)
    wr_en |-> cs_rise); // R2
  AST_FULL_FRAME_ONLY: assert property (@(posedge clk) disable iff (!pdn_n)
    wr_en |-> int'(bit_cnt) == FRAME_W); // R6
  AST_CHIP_MISMATCH_IGNORED: assert property (@(posedge clk) disable iff (!pdn_n)
    (frame_vld && frame_word[CHIP_LSB +: CHIP_W] != strap_addr) |=> $stable(watched)); // R3
  AST_READ_FLAG_IGNORED: assert property (@(posedge clk) disable iff (!pdn_n)
    (frame_vld && !frame_word[RW_POS]) |=> $stable(watched)); // R4
  AST_HIGH_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!pdn_n)
    (frame_vld && int'(f_addr) >= NUM_REGS) |=> $stable(watched)); // R5
  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!pdn_n)
    !wr_en |=> $stable(watched)); // R2
  AST_LEFT_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!pdn_n)
    (wr_en && int'(f_addr) == IDX_LVL0) |=> lvl_left == $past(frame_word[DATA_W-1:0])); // R7
  AST_SHARED_RUN_BIT: assert property (@(posedge clk) disable iff (!pdn_n)
    (wr_en && int'(f_addr) <= 1) |=> timing_run == $past(frame_word[0])); // R8
endmodule

bind ctl3w_regport ctl3w_regport_chk chk_i (.*);

// File: tb/ctl3w_regport_tb.sv
module ctl3w_regport_tb_top;
  logic clk = 1'b0;
  logic pdn_n = 1'b0;
  logic [1:0] strap_addr = 2'b10;
  logic csel_n = 1'b1, cclk = 1'b1, cdata = 1'b0;
  logic ext_clk_sel, lvl_link, smute, timing_run;
  logic [2:0] fmt_sel, mclk_sel;
  logic [1:0] fs_sel, spd_sel, deemph_sel;
  logic [3:0] mix_sel;
  logic [7:0] lvl_left, lvl_right;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [7:0] mdl [$];
  logic       mdl_run;

  always #10 clk = ~clk;

  ctl3w_regport dut_i (.*);

  function automatic logic [35:0] dut_vec();
    return {ext_clk_sel, fmt_sel, fs_sel, spd_sel, mclk_sel, mix_sel, deemph_sel,
            lvl_link, smute, timing_run, lvl_left, lvl_right};
  endfunction

  function automatic logic [35:0] mdl_vec();
    logic [7:0] a = mdl[0], b = mdl[1], c = mdl[2];
    return {a[4], a[3:1], b[7:6], b[5:4], b[3:1], c[7:4], c[3:2], c[1], c[0],
            mdl_run, mdl[3], mdl[4]};
  endfunction

  task automatic mdl_defaults();
    mdl = '{8'h0B, 8'h01, 8'h94, 8'hFF, 8'hFF};
    mdl_run = 1'b1;
  endtask

  task automatic mdl_apply(input logic [15:0] w);
    int idx = int'(w[12:8]);
    if (w[15:14] != strap_addr || w[13] !== 1'b1 || idx > 4) return;
    mdl[idx] = w[7:0];
    if (idx < 2) mdl_run = w[0];
  endtask

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(posedge clk) begin
    #5;
    if (!done) check("R7 model compare", dut_vec(), mdl_vec());
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input logic [1:0] chip, input logic rw,
                                     input int idx, input logic [7:0] d);
    return {chip, rw, 5'(idx), d};
  endfunction

  task automatic send(input logic [15:0] w, input int edges = 16, input int hold = 4);
    @(negedge clk); csel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < edges; i++) begin
      cclk = 1'b0;
      cdata = (i < 16) ? w[15-i] : 1'b1;
      repeat (4) @(negedge clk);
      cclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (hold) @(negedge clk);
    csel_n = 1'b1;
    repeat (3) @(posedge clk);
    if (edges == 16 && pdn_n) mdl_apply(w);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [35:0] snap;
    mdl_defaults();
    repeat (3) @(negedge clk);
    // R1: defaults while held in power-down
    check("R1 defaults", dut_vec(),
          {1'b0, 3'b101, 2'b00, 2'b00, 3'b000, 4'b1001, 2'b01, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF});
    pdn_n = 1'b1;
    repeat (4) @(negedge clk);

    send(mk(2'b10, 1, 3, 8'h5A));
    check("R2 left level via frame", {28'd0, lvl_left}, 36'h5A);
    send(mk(2'b10, 1, 4, 8'h3C));
    check("R7 right level", {28'd0, lvl_right}, 36'h3C);
    send(mk(2'b10, 1, 0, 8'h1E));
    check("R7 index0 fields", {32'd0, ext_clk_sel, fmt_sel}, {32'd0, 1'b1, 3'b111});
    check("R8 run cleared by index0", {35'd0, timing_run}, 36'd0);
    check("R9 levels kept with run cleared", {20'd0, lvl_left, lvl_right}, {20'd0, 16'h5A3C});
    send(mk(2'b10, 1, 1, 8'hF5));
    check("R7 index1 fields", {29'd0, fs_sel, spd_sel, mclk_sel}, {29'd0, 7'b1111010});
    check("R8 run set by index1", {35'd0, timing_run}, 36'd1);
    send(mk(2'b10, 1, 2, 8'h6B));
    check("R7 index2 fields", {28'd0, mix_sel, deemph_sel, lvl_link, smute}, {28'd0, 8'h6B});

    snap = dut_vec();
    send(mk(2'b01, 1, 3, 8'h00));
    check("R3 chip mismatch", dut_vec(), snap);
    send(mk(2'b10, 0, 4, 8'h00));
    check("R4 direction 0", dut_vec(), snap);
    send(mk(2'b10, 1, 5, 8'h00));
    send(mk(2'b10, 1, 31, 8'h00));
    send(mk(2'b10, 1, 19, 8'h00));
    check("R5 high indices", dut_vec(), snap);
    send(mk(2'b10, 1, 3, 8'h11), 15);
    check("R6 15 edges", dut_vec(), snap);
    send(mk(2'b10, 1, 3, 8'h22), 17);
    check("R6 17 edges", dut_vec(), snap);

    // R2: long hold with select low must not commit early
    fork
      send(mk(2'b10, 1, 4, 8'hC3), 16, 40);
      begin
        repeat (4 + 16 * 8 + 30) @(negedge clk);
        check("R2 no commit before release", {28'd0, lvl_right}, 36'h3C);
      end
    join
    check("R2 commit after release", {28'd0, lvl_right}, 36'hC3);

    send(mk(2'b10, 1, 0, 8'h00));
    send(mk(2'b10, 1, 1, 8'h01));
    check("R8 last write wins", {35'd0, timing_run}, 36'd1);

    // R1/R9: power-down restores defaults and loses writes
    @(negedge clk); pdn_n = 1'b0; mdl_defaults();
    @(negedge clk);
    check("R1 defaults after power-down", {20'd0, lvl_left, lvl_right}, {20'd0, 16'hFFFF});
    send(mk(2'b10, 1, 3, 8'h77));
    pdn_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 write lost in power-down", {28'd0, lvl_left}, 36'hFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule